// File: doc/BRIEF.md
# Stop-Bit Issue Group Sequencer

This block sits between instruction fetch and a parallel execution back end. Fetch delivers fixed-size bundles of three operation syllables. Every syllable carries a stop bit, and a set stop bit closes the current issue group: every syllable from the previous close up to and including this one may execute in parallel. Groups ignore bundle edges, so a group can begin in the middle of one bundle and end several bundles later.

The sequencer keeps arriving syllables in a small ring buffer. On each cycle it hands the next `N` syllables of the open group to an `N`-lane issue port. A group that is wider than the machine therefore takes several cycles. A group never shares an issue cycle with its neighbours. The first cycle of each group is marked, and so is the last, so that the back end can latch its register read snapshot at the start and hold its write-back until the end. While a group is in flight the block records every register that it writes and every register that it reads. It raises a flag on any cycle that carries a syllable which writes a register already written in the group, writes a register that another syllable of the group reads, or reads a register that another syllable of the group writes.

Top module: `stopbit_issue_seq`

## Requirements
- R1: `in_ready` is high exactly when the buffer has room for three more syllables (buffer depth `DEPTH`). A bundle is taken on a rising edge where both `in_valid` and `in_ready` are high. Syllable 0 sits in bits `[SYL_W-1:0]` of `in_bundle`, and syllables 1 and 2 follow in the next higher fields.
- R2: Syllables leave in arrival order. In each cycle the valid lanes form a prefix (lane 0 up to lane k-1), and lane j carries `slot_syl[j*SYL_W +: SYL_W]`. A syllable is laid out as {stop (MSB), destination, source A, source B, opcode (`OP_W` LSBs)}, and each register field is `REG_W` bits wide.
- R3: A cycle that does not close its group fills all `N` lanes.
- R4: A syllable whose stop bit is set is always in the last valid lane of its cycle. `grp_end` is high in exactly the issue cycles whose last syllable has its stop bit set. The next group starts in a later cycle.
- R5: `grp_start` is high exactly in the first issue cycle of each group and is low in cycles that issue nothing.
- R6: Nothing issues while the open group has fewer than `N` syllables buffered and none of them has its stop bit set. Once a stop bit arrives, the group issues completely.
- R7: `waw_flag` is high in an issue cycle when some syllable in that cycle has a destination that an earlier syllable of the same group also writes.
- R8: `raw_flag` is high in an issue cycle when some syllable in that cycle writes a register that an earlier syllable of the group reads, or reads a register that an earlier syllable of the group writes. A syllable that reads its own destination does not raise the flag.
- R9: After reset no lane is valid, both markers and both flags are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Buffer can take a bundle |
| in_bundle | input | 3*SYL_W | Three syllables, syllable 0 in the low field |
| slot_vld | output | N | Per-lane valid, always a prefix |
| slot_syl | output | N*SYL_W | Issued syllables, lane 0 in the low field |
| grp_start | output | 1 | First issue cycle of a group |
| grp_end | output | 1 | Last issue cycle of a group |
| waw_flag | output | 1 | Double write inside the current group |
| raw_flag | output | 1 | Write/read overlap inside the current group |

## Verification
The bench builds the block with four lanes, an eight-entry buffer, 7-bit register fields and 8-bit opcodes. With these values a group of five or more syllables spans two issue cycles, three buffered syllables with no stop bit leave the block waiting, and the buffer fills far enough to drop `in_ready`. Register numbers are drawn mostly from 0 to 7, with some from 120 to 127. The small range makes repeated writes and read/write overlaps frequent, and the high values exercise the top bits of the 128-entry tracking masks.

// File: rtl/sbis_pkg.sv
package sbis_pkg;
   localparam int SYL_PER_BUNDLE = 3;
   localparam int MAX_LANES      = 6;

   function automatic int syl_bits(int reg_w, int op_w);
      return 1 + 3 * reg_w + op_w;
   endfunction
endpackage

// File: rtl/sbis_buf.sv
module sbis_buf #(
   parameter int DEPTH = 8,
   parameter int SYL_W = 30,
   parameter int LANES = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      wr_en,
   input  logic [sbis_pkg::SYL_PER_BUNDLE*SYL_W-1:0] wr_data,
   input  logic [$clog2(LANES+1)-1:0]                rd_num,
   output logic [LANES*SYL_W-1:0]                    peek,
   output logic [$clog2(DEPTH+1)-1:0]                level,
   output logic                                      room
);
   localparam int WR_SYL = sbis_pkg::SYL_PER_BUNDLE;
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH+1);

   logic [SYL_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int w = 0; w < WR_SYL; w++)
            mem[wr_ptr + PTR_W'(w)] <= wr_data[w*SYL_W +: SYL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + PTR_W'(WR_SYL);
         rd_ptr <= rd_ptr + PTR_W'(rd_num);
         level  <= level + (wr_en ? CNT_W'(WR_SYL) : CNT_W'(0)) - CNT_W'(rd_num);
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_peek
      assign peek[j*SYL_W +: SYL_W] = mem[rd_ptr + PTR_W'(j)];
   end

   assign room = (int'(level) + WR_SYL) <= DEPTH;
endmodule

// File: rtl/sbis_pick.sv
module sbis_pick #(
   parameter int DEPTH = 8,
   parameter int SYL_W = 30,
   parameter int LANES = 4
) (
   input  logic [LANES*SYL_W-1:0]     peek,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   output logic [$clog2(LANES+1)-1:0] take_num,
   output logic [LANES-1:0]           take_mask,
   output logic                       ends
);
   localparam int TAKE_W = $clog2(LANES+1);

   always_comb begin
      int  pos;
      int  take;
      logic found;
      found = 1'b0;
      pos   = 0;
      for (int j = 0; j < LANES; j++) begin
         if (!found && (j < int'(level)) && peek[j*SYL_W + SYL_W - 1]) begin
            found = 1'b1;
            pos   = j;
         end
      end
      if (found)                      take = pos + 1;
      else if (int'(level) >= LANES)  take = LANES;
      else                            take = 0;
      ends     = found;
      take_num = TAKE_W'(take);
      for (int j = 0; j < LANES; j++) take_mask[j] = (j < take);
   end
endmodule

// File: rtl/sbis_hazard.sv
module sbis_hazard #(
   parameter int LANES = 4,
   parameter int REG_W = 7,
   parameter int OP_W  = 8,
   parameter int SYL_W = 30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       take_mask,
   input  logic [LANES*SYL_W-1:0] syl,
   input  logic                   grp_done,
   output logic                   waw,
   output logic                   raw
);
   localparam int NREG  = 1 << REG_W;
   localparam int SB_LO = OP_W;
   localparam int SA_LO = OP_W + REG_W;
   localparam int DS_LO = OP_W + 2*REG_W;

   logic [NREG-1:0] wr_m, rd_m, wr_n, rd_n;
   logic            waw_p, raw_p, waw_x, raw_x;

   // hazards against syllables issued in earlier cycles of the group
   always_comb begin
      logic [REG_W-1:0] d, a, b;
      waw_p = 1'b0;
      raw_p = 1'b0;
      wr_n  = wr_m;
      rd_n  = rd_m;
      for (int j = 0; j < LANES; j++) begin
         d = syl[j*SYL_W + DS_LO +: REG_W];
         a = syl[j*SYL_W + SA_LO +: REG_W];
         b = syl[j*SYL_W + SB_LO +: REG_W];
         if (take_mask[j]) begin
            waw_p   = waw_p | wr_m[d];
            raw_p   = raw_p | rd_m[d] | wr_m[a] | wr_m[b];
            wr_n[d] = 1'b1;
            rd_n[a] = 1'b1;
            rd_n[b] = 1'b1;
         end
      end
   end

   // hazards between lanes of the same cycle
   if (LANES > 1) begin : g_pair
      always_comb begin
         logic [REG_W-1:0] di, ai, bi, dj, aj, bj;
         waw_x = 1'b0;
         raw_x = 1'b0;
         for (int j = 1; j < LANES; j++) begin
            dj = syl[j*SYL_W + DS_LO +: REG_W];
            aj = syl[j*SYL_W + SA_LO +: REG_W];
            bj = syl[j*SYL_W + SB_LO +: REG_W];
            for (int i = 0; i < j; i++) begin
               di = syl[i*SYL_W + DS_LO +: REG_W];
               ai = syl[i*SYL_W + SA_LO +: REG_W];
               bi = syl[i*SYL_W + SB_LO +: REG_W];
               if (take_mask[j] && take_mask[i]) begin
                  waw_x = waw_x | (di == dj);
                  raw_x = raw_x | (di == aj) | (di == bj) | (dj == ai) | (dj == bi);
               end
            end
         end
      end
   end else begin : g_single
      assign waw_x = 1'b0;
      assign raw_x = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_m <= '0;
         rd_m <= '0;
      end else if (|take_mask) begin
         wr_m <= grp_done ? '0 : wr_n;
         rd_m <= grp_done ? '0 : rd_n;
      end
   end

   assign waw = waw_p | waw_x;
   assign raw = raw_p | raw_x;
endmodule

// File: rtl/stopbit_issue_seq.sv
module stopbit_issue_seq #(
   parameter int N     = 4,
   parameter int DEPTH = 8,
   parameter int REG_W = 7,
   parameter int OP_W  = 8,
   localparam int SYL_W = sbis_pkg::syl_bits(REG_W, OP_W)
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      in_valid,
   output logic                                      in_ready,
   input  logic [sbis_pkg::SYL_PER_BUNDLE*SYL_W-1:0] in_bundle,
   output logic [N-1:0]                              slot_vld,
   output logic [N*SYL_W-1:0]                        slot_syl,
   output logic                                      grp_start,
   output logic                                      grp_end,
   output logic                                      waw_flag,
   output logic                                      raw_flag
);
   localparam int CNT_W  = $clog2(DEPTH+1);
   localparam int TAKE_W = $clog2(N+1);

   if (N < 1 || N > sbis_pkg::MAX_LANES) begin : g_bad_lanes
      $error("stopbit_issue_seq: N out of range");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth_pow2
      $error("stopbit_issue_seq: DEPTH must be a power of two");
   end
   if (DEPTH < N + 2) begin : g_bad_depth_small
      $error("stopbit_issue_seq: DEPTH must be at least N+2");
   end

   logic [N*SYL_W-1:0] peek;
   logic [CNT_W-1:0]   level;
   logic               room;
   logic [TAKE_W-1:0]  take_num;
   logic [N-1:0]       take_mask;
   logic               ends, waw, raw, grp_open;

   sbis_buf #(.DEPTH(DEPTH), .SYL_W(SYL_W), .LANES(N)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(in_valid && room), .wr_data(in_bundle),
      .rd_num(take_num), .peek(peek), .level(level), .room(room)
   );

   sbis_pick #(.DEPTH(DEPTH), .SYL_W(SYL_W), .LANES(N)) u_pick (
      .peek(peek), .level(level),
      .take_num(take_num), .take_mask(take_mask), .ends(ends)
   );

   sbis_hazard #(.LANES(N), .REG_W(REG_W), .OP_W(OP_W), .SYL_W(SYL_W)) u_haz (
      .clk(clk), .rst_n(rst_n), .take_mask(take_mask), .syl(peek),
      .grp_done(ends), .waw(waw), .raw(raw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_vld  <= '0;
         slot_syl  <= '0;
         grp_start <= 1'b0;
         grp_end   <= 1'b0;
         waw_flag  <= 1'b0;
         raw_flag  <= 1'b0;
         grp_open  <= 1'b0;
      end else begin
         slot_vld  <= take_mask;
         slot_syl  <= peek;
         grp_start <= (|take_mask) && !grp_open;
         grp_end   <= ends;
         waw_flag  <= waw;
         raw_flag  <= raw;
         if (|take_mask) grp_open <= !ends;
      end
   end

   assign in_ready = room;
endmodule

// File: rtl/sbis_chk.sv
module sbis_chk #(
   parameter int N     = 4,
   parameter int SYL_W = 30
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N-1:0]       slot_vld,
   input logic [N*SYL_W-1:0] slot_syl,
   input logic               grp_start,
   input logic               grp_end,
   input logic               waw_flag,
   input logic               raw_flag
);
   logic open_q, last_stop, early_stop;

   always_comb begin
      int k;
      k          = $countones(slot_vld);
      last_stop  = 1'b0;
      early_stop = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (j == k - 1)    last_stop  = slot_syl[j*SYL_W + SYL_W - 1];
         else if (j < k - 1) early_stop = early_stop | slot_syl[j*SYL_W + SYL_W - 1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         open_q <= 1'b0;
      else if (|slot_vld) open_q <= !grp_end;
   end

   p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_vld & (slot_vld + N'(1))) == '0));
   p_full_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|slot_vld) && !grp_end) |-> (&slot_vld));
   p_stop_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_vld) |-> (!early_stop && (grp_end == last_stop)));
   p_end_issues_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grp_end |-> (|slot_vld));
   p_start_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_vld) |-> (grp_start == !open_q));
   p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(|slot_vld) |-> !grp_start);
   p_waw_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
      waw_flag |-> (|slot_vld));
   p_raw_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      raw_flag |-> (|slot_vld));
endmodule

bind stopbit_issue_seq sbis_chk #(.N(N), .SYL_W(SYL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_syl(slot_syl),
   .grp_start(grp_start), .grp_end(grp_end),
   .waw_flag(waw_flag), .raw_flag(raw_flag)
);

// File: tb/tb_stopbit_issue_seq.sv
module tb_stopbit_issue_seq;
   localparam int N     = 4;
   localparam int DEPTH = 8;
   localparam int REG_W = 7;
   localparam int OP_W  = 8;
   localparam int SW    = 1 + 3*REG_W + OP_W;
   localparam int QMAX  = 16384;
   localparam int RAND_END = 1500;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            in_ready;
   logic [3*SW-1:0] in_bundle;
   logic [N-1:0]    slot_vld;
   logic [N*SW-1:0] slot_syl;
   logic            grp_start, grp_end, waw_flag, raw_flag;

   always #10 clk = ~clk;

   stopbit_issue_seq #(.N(N), .DEPTH(DEPTH), .REG_W(REG_W), .OP_W(OP_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_bundle(in_bundle), .slot_vld(slot_vld), .slot_syl(slot_syl),
      .grp_start(grp_start), .grp_end(grp_end),
      .waw_flag(waw_flag), .raw_flag(raw_flag)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [SW-1:0] q [QMAX];
   int qh = 0, qt = 0;
   logic [127:0] wr_s = '0, rd_s = '0;
   bit open_g = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] mk(input bit stop, input logic [6:0] d,
                                        input logic [6:0] a, input logic [6:0] b,
                                        input logic [7:0] op);
      return {stop, d, a, b, op};
   endfunction

   function automatic logic [6:0] rreg();
      return ($urandom % 4 == 0) ? 7'(120 + $urandom % 8) : 7'($urandom % 8);
   endfunction

   function automatic logic [SW-1:0] rsyl();
      return mk(($urandom % 3) == 0, rreg(), rreg(), rreg(), 8'($urandom));
   endfunction

   task automatic check_outputs();
      int k;
      bit ew, er, last;
      logic [SW-1:0] s;
      logic [6:0] d, a, b;
      k = 0;
      for (int j = 0; j < N; j++) if (slot_vld[j]) k++;
      for (int j = 1; j < N; j++)
         if (slot_vld[j] && !slot_vld[j-1])
            chk(1'b0, "R2", "valid lanes not a prefix", 64'(slot_vld), 64'(0));
      if (k == 0) begin
         chk(!grp_start && !grp_end && !waw_flag && !raw_flag, "R5",
             "markers while idle", {grp_start, grp_end, waw_flag, raw_flag}, 64'(0));
         return;
      end
      chk(grp_start == !open_g, "R5", "group start marker", 64'(grp_start), 64'(!open_g));
      ew = 1'b0; er = 1'b0; last = 1'b0;
      for (int j = 0; j < k; j++) begin
         s = slot_syl[j*SW +: SW];
         if (qh < qt) begin
            chk(s == q[qh], "R2", "issued syllable order", 64'(s), 64'(q[qh]));
            qh++;
         end else chk(1'b0, "R2", "issue with nothing expected", 64'(s), 64'(0));
         last = s[SW-1];
         if (last && j != k - 1)
            chk(1'b0, "R4", "stop bit not in last lane", 64'(j), 64'(k-1));
         d = s[OP_W+2*REG_W +: REG_W];
         a = s[OP_W+REG_W +: REG_W];
         b = s[OP_W +: REG_W];
         ew = ew | wr_s[d];
         er = er | rd_s[d] | wr_s[a] | wr_s[b];
         wr_s[d] = 1'b1; rd_s[a] = 1'b1; rd_s[b] = 1'b1;
      end
      chk(grp_end == last, "R4", "group end marker", 64'(grp_end), 64'(last));
      if (!last) chk(k == N, "R3", "partial cycle inside group", 64'(k), 64'(N));
      chk(waw_flag == ew, "R7", "double write flag", 64'(waw_flag), 64'(ew));
      chk(raw_flag == er, "R8", "read/write overlap flag", 64'(raw_flag), 64'(er));
      if (last) begin
         wr_s = '0; rd_s = '0; open_g = 1'b0;
      end else open_g = 1'b1;
   endtask

   task automatic next_stim(input int step);
      in_valid = 1'b1;
      if (step == 0)
         in_bundle = {mk(0,7'd3,7'd1,7'd2,8'h10), mk(0,7'd4,7'd1,7'd2,8'h11), mk(0,7'd5,7'd6,7'd7,8'h12)};
      else if (step >= 1 && step <= 6)
         in_valid = 1'b0;
      else if (step == 7)   // closes a five-syllable group, last syllable opens the next
         in_bundle = {mk(0,7'd9,7'd0,7'd0,8'h22), mk(1,7'd8,7'd0,7'd0,8'h21), mk(0,7'd6,7'd0,7'd0,8'h20)};
      else if (step == 8)   // three single-syllable groups (first closes the pending one)
         in_bundle = {mk(1,7'd2,7'd2,7'd2,8'h32), mk(1,7'd1,7'd1,7'd1,8'h31), mk(1,7'd127,7'd126,7'd125,8'h30)};
      else if (step == 9)   // double write of r10
         in_bundle = {mk(1,7'd10,7'd3,7'd4,8'h42), mk(0,7'd10,7'd1,7'd2,8'h41), mk(1,7'd0,7'd0,7'd0,8'h40)};
      else if (step == 10)  // own read is fine; later write of a read register is not
         in_bundle = {mk(1,7'd13,7'd0,7'd0,8'h52), mk(0,7'd12,7'd13,7'd14,8'h51), mk(1,7'd11,7'd11,7'd11,8'h50)};
      else if (step < RAND_END) begin
         in_valid  = ($urandom % 5) != 0;
         in_bundle = {rsyl(), rsyl(), rsyl()};
      end else if (step == RAND_END)
         in_bundle = {mk(1,7'd1,7'd2,7'd3,8'h01), mk(1,7'd4,7'd5,7'd6,8'h02), mk(1,7'd7,7'd8,7'd9,8'h03)};
      else
         in_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      bit acc_last;
      int step;
      void'($urandom(32'd4242));
      rst_n = 1'b0; in_valid = 1'b0; in_bundle = '0;
      acc_last = 1'b0; step = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(slot_vld == '0, "R9", "lanes after reset", 64'(slot_vld), 64'(0));
      chk(!grp_start && !grp_end, "R9", "markers after reset", {grp_start, grp_end}, 64'(0));
      chk(!waw_flag && !raw_flag, "R9", "flags after reset", {waw_flag, raw_flag}, 64'(0));
      chk(in_ready == 1'b1, "R9", "ready after reset", 64'(in_ready), 64'(1));
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 5000; cyc++) begin
         @(negedge clk);
         check_outputs();
         chk(in_ready == ((DEPTH - (qt - qh)) >= 3), "R1", "ready vs buffer room",
             64'(in_ready), 64'((DEPTH - (qt - qh)) >= 3));
         if (cyc >= 2 && cyc <= 6)
            chk(slot_vld == '0, "R6", "issue while group short and open", 64'(slot_vld), 64'(0));
         if (!in_valid || acc_last) begin
            next_stim(step);
            step++;
         end
         acc_last = in_valid && in_ready;
         if (acc_last) begin
            for (int w = 0; w < 3; w++) begin
               q[qt] = in_bundle[w*SW +: SW];
               qt++;
            end
         end
      end
      chk(step > RAND_END, "R1", "stimulus fully accepted", 64'(step), 64'(RAND_END + 1));
      chk(qh == qt, "R6", "groups drained after final stop", 64'(qt - qh), 64'(0));
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule